// File: doc/BRIEF.md
# Programmable Interval Timer Channel

One 16-bit up-counter channel. The count advances once for each tick of a programmable clock divider. A mode register selects what happens when the count hits the programmed target value. In one setting the count returns to zero at the target. In the other it runs on past the target and folds back to zero only after 0xFFFF. Each target hit and each rollover can request an interrupt. The request can be allowed once per arming or every time. The result is a one-cycle pulse on `irq`, intended for an external interrupt controller.

Software reaches the channel through three registers, selected by a 2-bit address: count (0), mode (1) and target (2). Address 3 reads as zero. Writes take effect on the clock edge that samples `wrEn`. Reads are combinational, so `rdData` follows `addr` at once. The mode register also carries status bits that stay set until they are cleared.

Mode word layout:
- bit 0: wrap at target
- bit 1: interrupt on target hit
- bit 2: interrupt on rollover
- bit 3: repeat interrupts
- bits 7:4: divider rate
- bit 8: interrupt-fired state (read only)
- bit 9: wrap seen (read only)
- bit 10: target hit (read only)
- bit 11: rollover (read only)
- bits 15:12: read as zero

Top module: `ival_timer`

## Requirements
- R1: While reset is held, count, mode and target all read 0 and `irq` is low.
- R2: With rate field N (bits 7:4) of 2 or more, the count advances by one every N clock cycles, counted from the mode write. With N of 0 or 1 it advances every cycle. The count never changes by anything other than +1 or a return to 0, except through a register write.
- R3: With bit 0 set, a tick whose incremented value equals the target loads 0 instead, so the count cycles through 0..target-1. A target of 0 never matches.
- R4: With bit 0 clear, a target hit leaves the count running past the target.
- R5: A tick at count 0xFFFF produces 0 and is a rollover event.
- R6: A target hit requests an interrupt only when bit 1 is set. A rollover requests one only when bit 2 is set.
- R7: With bit 3 clear, a request raises `irq` only if bit 8 is clear. Raising `irq` sets bit 8, so at most one pulse occurs per arming.
- R8: With bit 3 set, every enabled request raises `irq`.
- R9: A target hit sets bit 10 and a rollover sets bit 11. Both stay set until cleared.
- R10: Bit 9 sets on every wrap: a return to 0 at the target with bit 0 set, or a rollover. A target hit with bit 0 clear does not set it.
- R11: Writing the target leaves the count as it was, apart from the regular tick in that cycle. Later matches use the new value.
- R12: Writing the mode register sets the count to 0 and clears bits 8 to 11. A read of the mode register with `rdEn` clears bits 10 and 11 but keeps bit 9.
- R13: `irq` goes high for exactly the one cycle after the edge at which the request occurred. While `irq` is high, bit 8 reads 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the register at `addr` |
| rdEn | input | 1 | Read strobe; used only to clear status on mode reads |
| addr | input | 2 | Register select: 0 count, 1 mode, 2 target |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Combinational read data for `addr` |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The properties assume that `rstN` is low from time zero. They also assume that any jump of the count other than +1 or a return to zero follows a write in the previous cycle. The rollover property is therefore conditioned on the absence of such a write. The stimulus makes at most one register access per cycle and changes inputs 1 ns after the rising edge. Every divider, match and rollover event is predicted from the number of edges since the last mode or count write.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int ADDR_W = 2;
  localparam int RATE_W = 4;
  localparam int CFG_W  = 8;

  localparam logic [ADDR_W-1:0] ADDR_COUNT  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MODE   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_TARGET = 2'd2;

  // mode word bit positions
  localparam int B_WRAP     = 0;
  localparam int B_IRQT     = 1;
  localparam int B_IRQO     = 2;
  localparam int B_REP      = 3;
  localparam int B_RATE_LO  = 4;
  localparam int B_FIRED    = 8;
  localparam int B_WRAPSEEN = 9;
  localparam int B_HIT      = 10;
  localparam int B_OVF      = 11;

  // control -> datapath strobes
  typedef struct packed {
    logic              clearAll;
    logic              wrapAtTarget;
    logic [RATE_W-1:0] rate;
  } ctlStrobe_t;

  // datapath -> control events
  typedef struct packed {
    logic matchEv;
    logic ovfEv;
  } dpEvent_t;
endpackage

// File: rtl/tmr_datapath.sv
`timescale 1ns/1ps
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
)
(
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       ctl,
  input  logic             cntWr,
  input  logic             tgtWr,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] countVal,
  output logic [CNT_W-1:0] targetVal,
  output dpEvent_t         ev
);
  logic [RATE_W-1:0] preCnt;
  logic [RATE_W-1:0] preLast;
  logic              tick;
  logic              live;
  logic              hitTarget;
  logic [CNT_W:0]    incr;

  always_comb begin
    // rate 0 or 1 means no division
    preLast    = (ctl.rate > RATE_W'(1)) ? ctl.rate - RATE_W'(1) : '0;
    tick       = (preCnt == preLast);
    incr       = {1'b0, countVal} + {{CNT_W{1'b0}}, 1'b1};
    hitTarget  = (incr == {1'b0, targetVal});
    live       = tick & ~ctl.clearAll & ~cntWr;
    ev.matchEv = live & hitTarget;
    ev.ovfEv   = live & incr[CNT_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN)                      preCnt <= '0;
    else if (ctl.clearAll || tick)  preCnt <= '0;
    else                            preCnt <= preCnt + RATE_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)              countVal <= '0;
    else if (ctl.clearAll)  countVal <= '0;
    else if (cntWr)         countVal <= wrData;
    else if (tick) begin
      if (ev.matchEv && ctl.wrapAtTarget) countVal <= '0;
      else                                countVal <= incr[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)      targetVal <= '0;
    else if (tgtWr) targetVal <= wrData;
  end
endmodule

// File: rtl/tmr_control.sv
`timescale 1ns/1ps
module tmr_control
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
)
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeWr,
  input  logic             modeRd,
  input  logic [CFG_W-1:0] cfgData,
  input  dpEvent_t         ev,
  output ctlStrobe_t       ctl,
  output logic [CNT_W-1:0] modeWord,
  output logic             irq
);
  logic [CFG_W-1:0] cfg;
  logic fired, wrapSeen, tgtHit, ovfHit;
  logic wrapEv, fireReq, fire;

  always_comb begin
    ctl.clearAll     = modeWr;
    ctl.wrapAtTarget = cfg[B_WRAP];
    ctl.rate         = cfg[B_RATE_LO +: RATE_W];
    wrapEv  = (ev.matchEv & cfg[B_WRAP]) | ev.ovfEv;
    fireReq = (ev.matchEv & cfg[B_IRQT]) | (ev.ovfEv & cfg[B_IRQO]);
    fire    = fireReq & (cfg[B_REP] | ~fired);
  end

  always_comb begin
    modeWord             = '0;
    modeWord[CFG_W-1:0]  = cfg;
    modeWord[B_FIRED]    = fired;
    modeWord[B_WRAPSEEN] = wrapSeen;
    modeWord[B_HIT]      = tgtHit;
    modeWord[B_OVF]      = ovfHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg      <= '0;
      fired    <= 1'b0;
      wrapSeen <= 1'b0;
      tgtHit   <= 1'b0;
      ovfHit   <= 1'b0;
      irq      <= 1'b0;
    end else begin
      irq <= fire;
      if (modeWr) begin
        cfg      <= cfgData;
        fired    <= 1'b0;
        wrapSeen <= 1'b0;
        tgtHit   <= 1'b0;
        ovfHit   <= 1'b0;
      end else begin
        if (fire)   fired    <= 1'b1;
        if (wrapEv) wrapSeen <= 1'b1;
        tgtHit <= ev.matchEv | (tgtHit & ~modeRd);
        ovfHit <= ev.ovfEv   | (ovfHit & ~modeRd);
      end
    end
  end
endmodule

// File: rtl/ival_timer.sv
`timescale 1ns/1ps
module ival_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
)
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  output logic              irq
);
  ctlStrobe_t       ctl;
  dpEvent_t         ev;
  logic [CNT_W-1:0] countVal;
  logic [CNT_W-1:0] targetVal;
  logic [CNT_W-1:0] modeWord;
  logic             modeWr, modeRd, cntWr, tgtWr;

  always_comb begin
    modeWr = wrEn && (addr == ADDR_MODE);
    cntWr  = wrEn && (addr == ADDR_COUNT);
    tgtWr  = wrEn && (addr == ADDR_TARGET);
    modeRd = rdEn && (addr == ADDR_MODE);
    case (addr)
      ADDR_COUNT:  rdData = countVal;
      ADDR_MODE:   rdData = modeWord;
      ADDR_TARGET: rdData = targetVal;
      default:     rdData = '0;
    endcase
  end

  tmr_control #(.CNT_W(CNT_W)) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .modeWr   (modeWr),
    .modeRd   (modeRd),
    .cfgData  (wrData[CFG_W-1:0]),
    .ev       (ev),
    .ctl      (ctl),
    .modeWord (modeWord),
    .irq      (irq)
  );

  tmr_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .cntWr     (cntWr),
    .tgtWr     (tgtWr),
    .wrData    (wrData),
    .countVal  (countVal),
    .targetVal (targetVal),
    .ev        (ev)
  );
endmodule

// File: rtl/tmr_chk.sv
`timescale 1ns/1ps
module tmr_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
)
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [CNT_W-1:0]  countVal,
  input logic [CNT_W-1:0]  modeWord,
  input logic              irq
);
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(wrEn) && countVal != $past(countVal)) |->
      (countVal == $past(countVal) + CNT_W'(1) || countVal == '0));

  // R12
  mode_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_MODE) |=>
      (countVal == '0 && modeWord[B_OVF:B_FIRED] == '0));

  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ($past(modeWord[B_IRQT]) || $past(modeWord[B_IRQO])));

  // R13
  irq_fired_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> modeWord[B_FIRED]);

  // R7
  one_shot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !modeWord[B_REP]) |=> !irq);

  // R5
  rollover_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(countVal) == {CNT_W{1'b1}} && countVal == '0 && !$past(wrEn)) |->
      modeWord[B_WRAPSEEN]);
endmodule

bind ival_timer tmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .addr     (addr),
  .countVal (countVal),
  .modeWord (modeWord),
  .irq      (irq)
);

// File: tb/tb_ival_timer.sv
`timescale 1ns/1ps
module tb_ival_timer;
  import tmr_pkg::*;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic        rdEn;
  logic [1:0]  addr;
  logic [15:0] wrData;
  logic [15:0] rdData;
  logic        irq;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int irqSeen = 0;
  logic [15:0] v;

  ival_timer dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  always #4 clk = ~clk;

  always @(negedge clk) if (irq) irqSeen++;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=<50000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [15:0] mk(input logic wrap, input logic irqT,
                                     input logic irqO, input logic rep,
                                     input logic [3:0] rate);
    return {8'h00, rate, rep, irqO, irqT, wrap};
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] val);
    addr = a;
    #1;
    val = rdData;
  endtask

  task automatic rdMode(output logic [15:0] val);
    addr = ADDR_MODE; rdEn = 1'b1;
    #1;
    val = rdData;
    @(posedge clk); #1;
    rdEn = 1'b0;
  endtask

  task automatic testReset();
    peek(ADDR_COUNT, v);  check("R1", "count in reset", v, 16'h0000);
    peek(ADDR_MODE, v);   check("R1", "mode in reset", v, 16'h0000);
    peek(ADDR_TARGET, v); check("R1", "target in reset", v, 16'h0000);
    check("R1", "irq in reset", {15'b0, irq}, 16'h0000);
  endtask

  task automatic testRate();
    wr(ADDR_MODE, mk(0, 0, 0, 0, 4'd4));
    step(10); peek(ADDR_COUNT, v); check("R2", "rate4 after 10", v, 16'd2);
    step(2);  peek(ADDR_COUNT, v); check("R2", "rate4 after 12", v, 16'd3);
    wr(ADDR_MODE, mk(0, 0, 0, 0, 4'd0));
    step(7);  peek(ADDR_COUNT, v); check("R2", "rate0 after 7", v, 16'd7);
    wr(ADDR_MODE, mk(0, 0, 0, 0, 4'd1));
    step(5);  peek(ADDR_COUNT, v); check("R2", "rate1 after 5", v, 16'd5);
  endtask

  task automatic testWrap();
    wr(ADDR_TARGET, 16'd5);
    wr(ADDR_MODE, mk(1, 0, 0, 0, 4'd0));
    step(4); peek(ADDR_COUNT, v); check("R3", "before target", v, 16'd4);
    peek(ADDR_MODE, v); check("R9", "no flags yet", v, 16'h0001);
    step(1); peek(ADDR_COUNT, v); check("R3", "wrapped to 0", v, 16'd0);
    peek(ADDR_MODE, v); check("R10", "hit and wrap flags", v, 16'h0601);
    step(3); peek(ADDR_COUNT, v); check("R3", "second period", v, 16'd3);
  endtask

  task automatic testNoWrap();
    wr(ADDR_TARGET, 16'd3);
    wr(ADDR_MODE, mk(0, 0, 0, 0, 4'd0));
    step(5); peek(ADDR_COUNT, v); check("R4", "runs past target", v, 16'd5);
    peek(ADDR_MODE, v); check("R10", "hit without wrap flag", v, 16'h0400);
  endtask

  task automatic testOverflow();
    wr(ADDR_TARGET, 16'd0);
    wr(ADDR_MODE, mk(0, 0, 0, 0, 4'd0));
    wr(ADDR_COUNT, 16'hFFFD);
    step(2); peek(ADDR_COUNT, v); check("R5", "at top", v, 16'hFFFF);
    peek(ADDR_MODE, v); check("R9", "no overflow yet", v, 16'h0000);
    step(1); peek(ADDR_COUNT, v); check("R5", "rolled to 0", v, 16'h0000);
    peek(ADDR_MODE, v); check("R9", "overflow and wrap flags", v, 16'h0A00);
    rdMode(v); check("R12", "read returns flags", v, 16'h0A00);
    peek(ADDR_MODE, v); check("R12", "read cleared overflow only", v, 16'h0200);
    wr(ADDR_MODE, mk(0, 0, 0, 0, 4'd0));
    peek(ADDR_MODE, v); check("R12", "mode write clears flags", v, 16'h0000);
    peek(ADDR_COUNT, v); check("R12", "mode write zeroes count", v, 16'h0000);
  endtask

  task automatic testIrqEnable();
    wr(ADDR_TARGET, 16'd4);
    wr(ADDR_MODE, mk(1, 0, 0, 0, 4'd0));
    irqSeen = 0;
    step(13); check("R6", "matches with no enables", 16'(irqSeen), 16'd0);
    wr(ADDR_TARGET, 16'd0);
    wr(ADDR_MODE, mk(0, 1, 0, 0, 4'd0));
    wr(ADDR_COUNT, 16'hFFFE);
    irqSeen = 0;
    step(4); check("R6", "overflow with target enable only", 16'(irqSeen), 16'd0);
    wr(ADDR_MODE, mk(0, 0, 1, 0, 4'd0));
    wr(ADDR_COUNT, 16'hFFFE);
    irqSeen = 0;
    step(4); check("R6", "overflow with overflow enable", 16'(irqSeen), 16'd1);
  endtask

  task automatic testOneShot();
    wr(ADDR_TARGET, 16'd4);
    wr(ADDR_MODE, mk(1, 1, 0, 0, 4'd0));
    irqSeen = 0;
    step(18); check("R7", "one pulse over four matches", 16'(irqSeen), 16'd1);
    peek(ADDR_MODE, v); check("R13", "fired state bit", v & 16'h0100, 16'h0100);
    wr(ADDR_MODE, mk(1, 1, 0, 0, 4'd0));
    peek(ADDR_MODE, v); check("R12", "rearm clears fired", v, 16'h0003);
    irqSeen = 0;
    step(6); check("R7", "rearmed pulse", 16'(irqSeen), 16'd1);
  endtask

  task automatic testRepeat();
    wr(ADDR_MODE, mk(1, 1, 0, 1, 4'd0));
    irqSeen = 0;
    step(18); check("R8", "pulse per match", 16'(irqSeen), 16'd4);
  endtask

  task automatic testPulse();
    wr(ADDR_MODE, mk(1, 1, 0, 1, 4'd0));
    step(3); check("R13", "irq low before match", {15'b0, irq}, 16'd0);
    step(1); check("R13", "irq high after match", {15'b0, irq}, 16'd1);
    step(1); check("R13", "irq single cycle", {15'b0, irq}, 16'd0);
  endtask

  task automatic testTargetWrite();
    wr(ADDR_TARGET, 16'd0);
    wr(ADDR_MODE, mk(0, 0, 0, 0, 4'd0));
    step(6);
    wr(ADDR_TARGET, 16'h0100);
    peek(ADDR_COUNT, v); check("R11", "count kept on target write", v, 16'd7);
    wr(ADDR_TARGET, 16'd10);
    wr(ADDR_MODE, mk(1, 0, 0, 0, 4'd0));
    step(6);
    wr(ADDR_TARGET, 16'd8);
    peek(ADDR_COUNT, v); check("R11", "count kept, wrap mode", v, 16'd7);
    step(1); peek(ADDR_COUNT, v); check("R11", "wraps at new target", v, 16'd0);
  endtask

  initial begin
    rstN = 1'b0; wrEn = 1'b0; rdEn = 1'b0; addr = '0; wrData = '0;
    step(3);
    testReset();
    rstN = 1'b1;
    step(1);
    testRate();
    testWrap();
    testNoWrap();
    testOverflow();
    testIrqEnable();
    testOneShot();
    testRepeat();
    testPulse();
    testTargetWrite();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule